// File: doc/BRIEF.md
# Priority-Based Clock Reference Selector

This block watches a bank of timing reference inputs and chooses the one that steers a downstream phase-locked loop. Each reference arrives as a single-cycle edge strobe that is already synchronous to the local oscillator clock. For every input the block tracks two things. The first is whether edges are still arriving, against an idle timeout. The second is whether the number of edges counted over a fixed gate of local clock cycles stays close to an expected count. An input has to pass both checks for a programmable number of consecutive gates before it counts as qualified. This holdoff keeps a marginal source from being picked and dropped over and over.

The choice is made in one of two ways. In automatic mode the block takes the best qualified input according to a programmed priority per input. In manual mode it follows an index that software forces, and reports whether that input is usable. Each time the block moves to a different input, or regains a usable one, it raises a one-cycle switch strobe. The loop uses this strobe to start a frequency ramp and rebuild its phase, so that the change is hitless at the output.

Top module: `clk_ref_selector`

## Requirements
- R1: After reset every output is zero: `sel_idx`=0, `sel_valid`=0, `switch_pulse`=0, and all bits of the status vectors are 0.
- R2: `ref_present[i]` goes high one cycle after an edge on `ref_edge[i]`. It goes low once `los_timeout`+1 consecutive cycles have passed with no edge on that input.
- R3: A measurement gate is `GATE_LEN` local cycles long and starts at reset. On the last cycle of each gate, `ref_freq_ok[i]` is set to 1 if |edges counted in that gate − `expect_cnt`| ≤ `offset_limit`, and to 0 otherwise.
- R4: `ref_qualified[i]` rises only at the end of a gate, and only after `requal_gates` consecutive gates (a value of 0 counts as 1) in which the input was present and passed the offset check. A failing gate clears it. Loss of presence clears it one cycle later.
- R5: An input is eligible when it is qualified, its enable bit `ref_en[i]` is 1, and its 3-bit priority field `ref_prio[3*i+2:3*i]` is not 0. A disabled input or an input with priority 0 is never selected automatically.
- R6: With `auto_mode`=1, the eligible input with the smallest nonzero priority value is selected, so 1 is the most preferred and 7 the least.
- R7: In automatic mode, among eligible inputs that share the same priority value, the lowest index wins.
- R8: With `auto_mode`=1 and no input eligible, `sel_valid` is 0 and `sel_idx` keeps its previous value.
- R9: With `auto_mode`=0, `sel_idx` equals `manual_idx` and `sel_valid` equals `ref_qualified[manual_idx]`. When the forced input loses qualification, the selection stays where it is even if other inputs are eligible.
- R10: `sel_idx` and `sel_valid` update one cycle after a change in qualification. `switch_pulse` is high for exactly that one update cycle whenever the new selection is valid and either its index differs from the previous one or `sel_valid` was 0 before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | N_REF | One-cycle edge strobe per reference |
| ref_en | input | N_REF | Per-input enable for automatic selection |
| ref_prio | input | N_REF*PRIO_W | Packed priority fields, input i at bits [PRIO_W*i +: PRIO_W], 0 = never |
| auto_mode | input | 1 | 1 = automatic priority selection, 0 = forced index |
| manual_idx | input | IDX_W | Forced input index in manual mode |
| expect_cnt | input | CNT_W | Expected edge count per gate |
| offset_limit | input | CNT_W | Largest allowed deviation from expect_cnt |
| los_timeout | input | TMO_W | Idle cycles before an input is declared absent |
| requal_gates | input | HOLD_W | Consecutive passing gates needed to qualify |
| sel_idx | output | IDX_W | Selected reference index |
| sel_valid | output | 1 | Selected reference is usable |
| switch_pulse | output | 1 | One-cycle strobe on a new valid selection |
| ref_present | output | N_REF | Per-input presence status |
| ref_freq_ok | output | N_REF | Per-input result of the last gate's offset check |
| ref_qualified | output | N_REF | Per-input qualification after the holdoff |

## Verification
Presence is due one cycle after an edge, and absence is due `los_timeout`+1 idle cycles after the last edge. Offset status and qualification change only on the register edge that closes a gate, and the selection and the switch strobe follow one cycle after that. The bench therefore samples on falling edges, after waiting whole gates plus a margin, or after the timeout plus a margin, so that every result is already settled whatever the phase of the edge pattern. The switch strobe is counted on every falling edge of the run, which checks both that a switch fired and that it lasted only one cycle.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;

    typedef enum logic {
        SEL_FORCED = 1'b0,
        SEL_AUTO   = 1'b1
    } sel_mode_e;

    typedef struct packed {
        logic present;
        logic freq_ok;
        logic qualified;
    } ref_status_t;

    // Candidate beats current best when none chosen yet or strictly smaller value.
    function automatic logic prio_beats(input int unsigned cand,
                                        input int unsigned best,
                                        input logic        have_best);
        return !have_best || (cand < best);
    endfunction

endpackage

// File: rtl/refsel_gate_timer.sv
`timescale 1ns/1ps
module refsel_gate_timer #(
    parameter int unsigned GATE_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    output logic gate_end
);
    localparam int unsigned GW = (GATE_LEN > 1) ? $clog2(GATE_LEN) : 1;
    localparam logic [GW-1:0] LAST = GW'(GATE_LEN - 1);

    logic [GW-1:0] tick_q;

    assign gate_end = (tick_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else if (gate_end) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    AST_GATE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        gate_end |=> !gate_end); // R3

endmodule

// File: rtl/refsel_mon.sv
`timescale 1ns/1ps
module refsel_mon
    import refsel_pkg::*;
#(
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned TMO_W  = 8,
    parameter int unsigned HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_in,
    input  logic              gate_end,
    input  logic [CNT_W-1:0]  expect_cnt,
    input  logic [CNT_W-1:0]  offset_limit,
    input  logic [TMO_W-1:0]  los_timeout,
    input  logic [HOLD_W-1:0] requal_gates,
    output ref_status_t       status
);
    logic [TMO_W-1:0]  gap_q;
    logic              present_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              freq_ok_q;
    logic [HOLD_W-1:0] streak_q;
    logic              qual_q;

    logic [CNT_W:0]    total;
    logic [CNT_W:0]    dev;
    logic              win_pass;
    logic [HOLD_W-1:0] need;
    logic [HOLD_W:0]   streak_nxt;

    // Gate total includes an edge that lands on the closing cycle.
    always_comb begin
        total = {1'b0, cnt_q} + {{CNT_W{1'b0}}, edge_in};
        if (total >= {1'b0, expect_cnt}) begin
            dev = total - {1'b0, expect_cnt};
        end else begin
            dev = {1'b0, expect_cnt} - total;
        end
        win_pass   = (dev <= {1'b0, offset_limit});
        need       = (requal_gates == '0) ? HOLD_W'(1) : requal_gates;
        streak_nxt = {1'b0, streak_q} + {{HOLD_W{1'b0}}, 1'b1};
    end

    // Presence: idle-cycle watchdog per input.
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= '0;
            present_q <= 1'b0;
        end else if (edge_in) begin
            gap_q     <= '0;
            present_q <= 1'b1;
        end else if (gap_q == los_timeout) begin
            present_q <= 1'b0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Offset: edge count over one gate.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            freq_ok_q <= 1'b0;
        end else if (gate_end) begin
            cnt_q     <= '0;
            freq_ok_q <= win_pass;
        end else if (edge_in) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Qualification with holdoff over consecutive good gates.
    always_ff @(posedge clk) begin
        if (rst) begin
            qual_q   <= 1'b0;
            streak_q <= '0;
        end else if (!present_q) begin
            qual_q   <= 1'b0;
            streak_q <= '0;
        end else if (gate_end) begin
            if (!win_pass) begin
                qual_q   <= 1'b0;
                streak_q <= '0;
            end else if (!qual_q) begin
                if (streak_nxt >= {1'b0, need}) begin
                    qual_q   <= 1'b1;
                    streak_q <= '0;
                end else begin
                    streak_q <= streak_nxt[HOLD_W-1:0];
                end
            end
        end
    end

    assign status.present   = present_q;
    assign status.freq_ok   = freq_ok_q;
    assign status.qualified = qual_q;

    AST_PRESENT_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        edge_in |=> present_q); // R2

    AST_FREQ_ONLY_AT_GATE: assert property (@(posedge clk) disable iff (rst)
        !$past(gate_end) |-> $stable(freq_ok_q)); // R3

    AST_LOSS_CLEARS_QUAL: assert property (@(posedge clk) disable iff (rst)
        !present_q |=> !qual_q); // R4

    AST_QUAL_RISES_AT_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_q) |-> $past(gate_end)); // R4

endmodule

// File: rtl/refsel_arbiter.sv
`timescale 1ns/1ps
module refsel_arbiter
    import refsel_pkg::*;
#(
    parameter int unsigned N_REF  = 8,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REF-1:0]        qual_vec,
    input  logic [N_REF-1:0]        en_vec,
    input  logic [N_REF*PRIO_W-1:0] prio_flat,
    output logic [N_REF-1:0]        elig_vec,
    output logic [IDX_W-1:0]        best_idx,
    output logic                    any_elig
);
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        best_idx  = '0;
        best_prio = '0;
        any_elig  = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            elig_vec[i] = qual_vec[i] && en_vec[i] &&
                          (prio_flat[i*PRIO_W +: PRIO_W] != '0);
            if (elig_vec[i] &&
                prio_beats(int'(prio_flat[i*PRIO_W +: PRIO_W]), int'(best_prio), any_elig)) begin
                best_idx  = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                any_elig  = 1'b1;
            end
        end
    end

    AST_PICK_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        any_elig |-> elig_vec[best_idx]); // R5

    AST_NONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (elig_vec == '0) |-> !any_elig); // R8

endmodule

// File: rtl/clk_ref_selector.sv
`timescale 1ns/1ps
module clk_ref_selector
    import refsel_pkg::*;
#(
    parameter int unsigned N_REF    = 8,
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned GATE_LEN = 64,
    parameter int unsigned TMO_W    = 8,
    parameter int unsigned HOLD_W   = 4,
    localparam int unsigned IDX_W   = (N_REF > 1) ? $clog2(N_REF) : 1,
    localparam int unsigned CNT_W   = $clog2(GATE_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REF-1:0]        ref_edge,
    input  logic [N_REF-1:0]        ref_en,
    input  logic [N_REF*PRIO_W-1:0] ref_prio,
    input  logic                    auto_mode,
    input  logic [IDX_W-1:0]        manual_idx,
    input  logic [CNT_W-1:0]        expect_cnt,
    input  logic [CNT_W-1:0]        offset_limit,
    input  logic [TMO_W-1:0]        los_timeout,
    input  logic [HOLD_W-1:0]       requal_gates,
    output logic [IDX_W-1:0]        sel_idx,
    output logic                    sel_valid,
    output logic                    switch_pulse,
    output logic [N_REF-1:0]        ref_present,
    output logic [N_REF-1:0]        ref_freq_ok,
    output logic [N_REF-1:0]        ref_qualified
);
    logic              gate_end;
    ref_status_t       stat [N_REF];
    logic [N_REF-1:0]  elig_vec;
    logic [IDX_W-1:0]  best_idx;
    logic              any_elig;
    sel_mode_e         mode;

    logic [IDX_W-1:0]  sel_q, sel_nxt;
    logic              valid_q, valid_nxt;
    logic              switch_q;

    refsel_gate_timer #(.GATE_LEN(GATE_LEN)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .gate_end (gate_end)
    );

    for (genvar g = 0; g < N_REF; g++) begin : g_mon
        refsel_mon #(.CNT_W(CNT_W), .TMO_W(TMO_W), .HOLD_W(HOLD_W)) u_mon (
            .clk          (clk),
            .rst          (rst),
            .edge_in      (ref_edge[g]),
            .gate_end     (gate_end),
            .expect_cnt   (expect_cnt),
            .offset_limit (offset_limit),
            .los_timeout  (los_timeout),
            .requal_gates (requal_gates),
            .status       (stat[g])
        );
        assign ref_present[g]   = stat[g].present;
        assign ref_freq_ok[g]   = stat[g].freq_ok;
        assign ref_qualified[g] = stat[g].qualified;
    end

    refsel_arbiter #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .qual_vec  (ref_qualified),
        .en_vec    (ref_en),
        .prio_flat (ref_prio),
        .elig_vec  (elig_vec),
        .best_idx  (best_idx),
        .any_elig  (any_elig)
    );

    assign mode = sel_mode_e'(auto_mode);

    always_comb begin
        if (mode == SEL_AUTO) begin
            valid_nxt = any_elig;
            sel_nxt   = any_elig ? best_idx : sel_q;
        end else begin
            sel_nxt   = manual_idx;
            valid_nxt = ref_qualified[manual_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            valid_q  <= 1'b0;
            switch_q <= 1'b0;
        end else begin
            sel_q    <= sel_nxt;
            valid_q  <= valid_nxt;
            switch_q <= valid_nxt && ((sel_nxt != sel_q) || !valid_q);
        end
    end

    assign sel_idx      = sel_q;
    assign sel_valid    = valid_q;
    assign switch_pulse = switch_q;

    AST_FORCED_FOLLOWS_INDEX: assert property (@(posedge clk) disable iff (rst)
        $past(!auto_mode) |-> (sel_q == $past(manual_idx))); // R9

    AST_AUTO_EMPTY_INVALID: assert property (@(posedge clk) disable iff (rst)
        $past(auto_mode && (ref_qualified == '0)) |-> !valid_q); // R8

    AST_AUTO_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(auto_mode && (ref_qualified == '0)) |-> $stable(sel_q)); // R8

    AST_SWITCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        switch_q |-> valid_q); // R10

endmodule

// File: tb/clk_ref_selector_tb.sv
`timescale 1ns/1ps
module clk_ref_selector_tb_top;
    localparam int unsigned N_REF    = 8;
    localparam int unsigned PRIO_W   = 3;
    localparam int unsigned GATE_LEN = 64;
    localparam int unsigned TMO_W    = 8;
    localparam int unsigned HOLD_W   = 4;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned CNT_W    = 7;
    localparam int unsigned SETTLE   = 6 * GATE_LEN;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [N_REF-1:0]        ref_edge = '0;
    logic [N_REF-1:0]        ref_en = '0;
    logic [N_REF*PRIO_W-1:0] ref_prio = '0;
    logic                    auto_mode = 1'b1;
    logic [IDX_W-1:0]        manual_idx = '0;
    logic [CNT_W-1:0]        expect_cnt = 7'd16;
    logic [CNT_W-1:0]        offset_limit = 7'd2;
    logic [TMO_W-1:0]        los_timeout = 8'd20;
    logic [HOLD_W-1:0]       requal_gates = 4'd3;
    logic [IDX_W-1:0]        sel_idx;
    logic                    sel_valid;
    logic                    switch_pulse;
    logic [N_REF-1:0]        ref_present;
    logic [N_REF-1:0]        ref_freq_ok;
    logic [N_REF-1:0]        ref_qualified;

    int n_chk  = 0;
    int n_fail = 0;
    int sw_cnt = 0;
    int period [N_REF];
    int phase  [N_REF];

    always #2.5 clk = ~clk;

    clk_ref_selector #(
        .N_REF(N_REF), .PRIO_W(PRIO_W), .GATE_LEN(GATE_LEN),
        .TMO_W(TMO_W), .HOLD_W(HOLD_W)
    ) dut_i (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .ref_en(ref_en),
        .ref_prio(ref_prio), .auto_mode(auto_mode), .manual_idx(manual_idx),
        .expect_cnt(expect_cnt), .offset_limit(offset_limit),
        .los_timeout(los_timeout), .requal_gates(requal_gates),
        .sel_idx(sel_idx), .sel_valid(sel_valid), .switch_pulse(switch_pulse),
        .ref_present(ref_present), .ref_freq_ok(ref_freq_ok),
        .ref_qualified(ref_qualified)
    );

    // Reference edge generator: period 0 means silent.
    initial begin
        for (int i = 0; i < N_REF; i++) begin
            period[i] = 0;
            phase[i]  = 0;
        end
        forever begin
            @(negedge clk);
            for (int i = 0; i < N_REF; i++) begin
                if (period[i] == 0) begin
                    ref_edge[i] = 1'b0;
                    phase[i]    = 0;
                end else if (phase[i] == 0) begin
                    ref_edge[i] = 1'b1;
                    phase[i]    = period[i] - 1;
                end else begin
                    ref_edge[i] = 1'b0;
                    phase[i]    = phase[i] - 1;
                end
            end
        end
    end

    // Strobe counter, sampled away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (switch_pulse) sw_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_prio(input int idx, input int p);
        ref_prio[idx*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    task automatic do_reset();
        for (int i = 0; i < N_REF; i++) period[i] = 0;
        ref_en    = '0;
        ref_prio  = '0;
        auto_mode = 1'b1;
        manual_idx = '0;
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        sw_cnt = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 sel_idx", int'(sel_idx), 0);
        check("R1 sel_valid", int'(sel_valid), 0);
        check("R1 switch_pulse", int'(switch_pulse), 0);
        check("R1 status", int'({ref_present, ref_freq_ok, ref_qualified}), 0);
    endtask

    task automatic t_presence();
        do_reset();
        period[0] = 4;
        wait_cyc(30);
        check("R2 present with edges", int'(ref_present), 1);
        period[0] = 0;
        wait_cyc(12);
        check("R2 present inside timeout", int'(ref_present[0]), 1);
        wait_cyc(18);
        check("R2 absent after timeout", int'(ref_present), 0);
    endtask

    task automatic t_freq();
        do_reset();
        period[1] = 4;
        period[2] = 5;
        period[3] = 3;
        wait_cyc(3 * GATE_LEN);
        check("R3 freq_ok pattern", int'(ref_freq_ok), 32'h02);
        check("R2 present pattern", int'(ref_present), 32'h0E);
    endtask

    task automatic t_requal();
        do_reset();
        period[4] = 4;
        wait_cyc(2 * GATE_LEN);
        check("R4 not yet qualified", int'(ref_qualified[4]), 0);
        wait_cyc(3 * GATE_LEN + 8);
        check("R4 qualified after holdoff", int'(ref_qualified[4]), 1);
        period[4] = 5;
        wait_cyc(GATE_LEN + 8);
        check("R4 bad gate clears", int'(ref_qualified[4]), 0);
    endtask

    task automatic t_auto_priority();
        do_reset();
        for (int i = 0; i < N_REF; i++) ref_en[i] = 1'b1;
        period[1] = 4; set_prio(1, 3);
        period[2] = 4; set_prio(2, 2);
        period[5] = 4; set_prio(5, 2);
        wait_cyc(SETTLE);
        check("R6 R7 auto pick", int'(sel_idx), 2);
        check("R6 valid", int'(sel_valid), 1);
        check("R10 one strobe", sw_cnt, 1);
        // Failover: remove selected input.
        period[2] = 0;
        wait_cyc(40);
        check("R10 failover index", int'(sel_idx), 5);
        check("R10 second strobe", sw_cnt, 2);
        // Nothing left.
        period[1] = 0;
        period[5] = 0;
        wait_cyc(40);
        check("R8 invalid when empty", int'(sel_valid), 0);
        check("R8 index held", int'(sel_idx), 5);
        check("R8 no strobe", sw_cnt, 2);
    endtask

    task automatic t_ineligible();
        do_reset();
        ref_en = 8'hBF;          // input 6 disabled
        period[0] = 4; set_prio(0, 0);
        period[6] = 4; set_prio(6, 1);
        period[7] = 4; set_prio(7, 5);
        wait_cyc(SETTLE);
        check("R5 all qualified", int'(ref_qualified), 32'hC1);
        check("R5 skip disabled and zero", int'(sel_idx), 7);
        check("R5 valid", int'(sel_valid), 1);
    endtask

    task automatic t_manual();
        do_reset();
        auto_mode  = 1'b0;
        manual_idx = 3'd3;
        ref_en[1] = 1'b1; set_prio(1, 1);
        period[1] = 4;
        period[3] = 4;
        wait_cyc(SETTLE);
        check("R9 forced index", int'(sel_idx), 3);
        check("R9 forced valid", int'(sel_valid), 1);
        period[3] = 0;
        wait_cyc(40);
        check("R9 forced lost invalid", int'(sel_valid), 0);
        check("R9 forced held", int'(sel_idx), 3);
        check("R9 other still qualified", int'(ref_qualified[1]), 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_presence();
        t_freq();
        t_requal();
        t_auto_priority();
        t_ineligible();
        t_manual();
        finish_run();
    end

endmodule